// File: doc/BRIEF.md
# Program Flash Table-Access Guard

This block sits between a processor's table read/write path and a 16 KiB program flash. It decides, for every table access, whether the access may go ahead. Two addresses drive the decision: the address of the instruction doing the access (the program counter) and the byte address it targets (the table pointer). The flash is split into five protection regions. Each region has a write-enable bit and a foreign-read-enable bit. A write into a region whose write-enable bit is 0 never reaches the flash. A read from a region whose foreign-read-enable bit is 0 goes ahead only when the instruction doing the read lives in that same region. Any other read returns zeros.

The protection bits live inside the block and can only be cleared: a configuration write ANDs new values into them. They return to 1 only through a chip-wide erase or a region erase. An erase wins over a configuration write made in the same cycle. The write decision is combinational, so the flash write strobe appears in the cycle of the request. Read data passes through one register stage, which puts in zeros for a denied read. Each denied access raises a one-cycle violation pulse in step with that register stage.

Top module: `pfm_access_guard`

## Requirements
- R1: After reset all ten protection bits read 1 on `wp_o`/`rp_o`, and `rd_valid_o` and `violation_o` are 0.
- R2: Region index and bit position: bit 0 covers 0x0000-0x07FF, bit 1 covers 0x0800-0x0FFF, bit 2 covers 0x1000-0x1FFF, bit 3 covers 0x2000-0x2FFF and bit 4 covers 0x3000-0x3FFF. The same positions apply to `wp_o`, `rp_o`, `cfg_wp_i`, `cfg_rp_i` and `blk_erase_sel_i`.
- R3: `flash_we_o` equals `wr_req_i` in the same cycle when the target region's write-enable bit is 1. When that bit is 0, `flash_we_o` stays 0, whatever the program counter.
- R4: A read of a region whose foreign-read-enable bit is 1 is granted from any program counter. When the bit is 0, the read is granted if the program counter is in the same region.
- R5: A read of a region whose foreign-read-enable bit is 0, issued with the program counter outside that region, returns 0x00.
- R6: A target address at or above 0x4000 belongs to no region. A read of it returns 0x00, and a write to it is not forwarded to the flash.
- R7: One cycle after `rd_req_i`, `rd_valid_o` is 1 and `rd_data_o` holds the flash byte if the read was granted, or zero if it was not. `rd_valid_o` is 0 one cycle after a cycle with no read request.
- R8: `violation_o` is 1 for exactly the cycle after each cycle in which a read was zeroed or a write was suppressed, and 0 otherwise.
- R9: A configuration write (`cfg_wr_i`) sets each protection bit to old AND new. A 1 written to a bit that is 0 leaves it at 0.
- R10: `chip_erase_i` sets all ten protection bits to 1 at the next edge.
- R11: `blk_erase_i` sets to 1 both bits of the region selected by `blk_erase_sel_i` (0 to 4) and leaves all other bits unchanged. Selector values 5 to 7 change nothing.
- R12: When any erase request is present in a cycle, a configuration write in that same cycle is ignored. Chip erase also takes priority over region erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pc_i | input | 22 | Address of the instruction making the access |
| tptr_i | input | 22 | Byte address targeted by the table access |
| rd_req_i | input | 1 | Table read request |
| wr_req_i | input | 1 | Table write request |
| flash_rdata_i | input | 8 | Flash byte at `tptr_i`, valid in the request cycle |
| flash_we_o | output | 1 | Write strobe forwarded to the flash |
| rd_valid_o | output | 1 | Read result valid, one cycle after the request |
| rd_data_o | output | 8 | Read result, zero when the read was denied |
| violation_o | output | 1 | One-cycle pulse per denied access |
| cfg_wr_i | input | 1 | Configuration write strobe (clear-only) |
| cfg_wp_i | input | 5 | New write-enable bits, one per region |
| cfg_rp_i | input | 5 | New foreign-read-enable bits, one per region |
| chip_erase_i | input | 1 | Restore all protection bits to 1 |
| blk_erase_i | input | 1 | Restore the bits of one region to 1 |
| blk_erase_sel_i | input | 3 | Region index for a region erase |
| wp_o | output | 5 | Current write-enable bits |
| rp_o | output | 5 | Current foreign-read-enable bits |

## Verification
The bound checker checks several rules on every cycle. A write into region 1 with its write-enable bit clear never strobes the flash. A cross-region read of region 1 with its read bit clear comes back as zero with a violation pulse. Unmapped reads return zero. Protection bits never rise without an erase in the cycle before. A chip erase leaves all bits set. Other behaviours can only be shown by the bench's scenarios and its per-cycle model: the exact region boundaries, the same-region exception seen from every region, region-erase selection, erase-over-write priority, and read data matching what earlier granted writes left in the flash.

// File: rtl/pfm_guard_pkg.sv
package pfm_guard_pkg;

  // Outcome of one table access in one cycle.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PASS  = 2'd1,
    ACC_BLOCK = 2'd2
  } acc_verdict_e;

endpackage

// File: rtl/pfm_region_decode.sv
module pfm_region_decode #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned BOOT_BYTES = 2048,
  parameter int unsigned BLK_BYTES  = 4096,
  parameter int unsigned NUM_BLK    = 4,
  parameter int unsigned IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [IDX_W-1:0]  IDX_NONE  = {IDX_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOOT_LIM  = ADDR_W'(BOOT_BYTES);

  logic [NUM_BLK-1:0] in_win;
  logic               in_boot;

  // One address window per coarse block.
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_win
    localparam logic [ADDR_W-1:0] HI = ADDR_W'((g + 1) * BLK_BYTES - 1);
    if (g == 0) begin : g_first
      assign in_win[g] = (addr_i <= HI);
    end else begin : g_rest
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(g * BLK_BYTES);
      assign in_win[g] = (addr_i >= LO) && (addr_i <= HI);
    end
  end

  assign in_boot = in_win[0] && (addr_i < BOOT_LIM);

  always_comb begin
    idx_o = IDX_NONE;
    for (int g = 0; g < NUM_BLK; g++) begin
      if (in_win[g]) idx_o = IDX_W'(g + 1);
    end
    if (in_boot) idx_o = '0;
  end

endmodule

// File: rtl/pfm_prot_store.sv
module pfm_prot_store #(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_i,
  input  logic [NUM_REG-1:0] cfg_wp_i,
  input  logic [NUM_REG-1:0] cfg_rp_i,
  input  logic               chip_erase_i,
  input  logic               blk_erase_i,
  input  logic [IDX_W-1:0]   blk_sel_i,
  output logic [NUM_REG-1:0] wp_q_o,
  output logic [NUM_REG-1:0] rp_q_o
);

  logic [NUM_REG-1:0] wp_q, rp_q;
  logic [NUM_REG-1:0] wp_d, rp_d;
  logic [NUM_REG-1:0] erase_mask;
  logic               any_erase;
  logic               upd_en;

  // Bits to restore this cycle.
  for (genvar r = 0; r < NUM_REG; r++) begin : g_mask
    assign erase_mask[r] = chip_erase_i ||
                           (blk_erase_i && (blk_sel_i == IDX_W'(r)));
  end

  assign any_erase = chip_erase_i || blk_erase_i;
  assign upd_en    = any_erase || cfg_wr_i;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (any_erase) begin
      wp_d = wp_q | erase_mask;
      rp_d = rp_q | erase_mask;
    end else if (cfg_wr_i) begin
      wp_d = wp_q & cfg_wp_i;
      rp_d = rp_q & cfg_rp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '1;
      rp_q <= '1;
    end else if (upd_en) begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  assign wp_q_o = wp_q;
  assign rp_q_o = rp_q;

endmodule

// File: rtl/pfm_access_gate.sv
module pfm_access_gate
  import pfm_guard_pkg::*;
#(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   pc_idx_i,
  input  logic [IDX_W-1:0]   tgt_idx_i,
  input  logic [NUM_REG-1:0] wp_i,
  input  logic [NUM_REG-1:0] rp_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic [DATA_W-1:0]  flash_rdata_i,
  output logic               flash_we_o,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               violation_o
);

  logic         tgt_mapped, tgt_wp, tgt_rp, same_region;
  acc_verdict_e rd_verdict, wr_verdict;

  logic              rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              vio_q, vio_d;
  logic              rd_data_en;

  // Select the target region's bits without a variable-width index.
  always_comb begin
    tgt_mapped = 1'b0;
    tgt_wp     = 1'b0;
    tgt_rp     = 1'b0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (tgt_idx_i == IDX_W'(r)) begin
        tgt_mapped = 1'b1;
        tgt_wp     = wp_i[r];
        tgt_rp     = rp_i[r];
      end
    end
  end

  assign same_region = tgt_mapped && (pc_idx_i == tgt_idx_i);

  always_comb begin
    if (!rd_req_i)                                   rd_verdict = ACC_NONE;
    else if (tgt_mapped && (tgt_rp || same_region))  rd_verdict = ACC_PASS;
    else                                             rd_verdict = ACC_BLOCK;

    if (!wr_req_i)                                   wr_verdict = ACC_NONE;
    else if (tgt_mapped && tgt_wp)                   wr_verdict = ACC_PASS;
    else                                             wr_verdict = ACC_BLOCK;
  end

  assign flash_we_o = (wr_verdict == ACC_PASS);

  // Next state of the read-result stage.
  always_comb begin
    rd_valid_d = (rd_verdict != ACC_NONE);
    rd_data_en = rd_req_i;
    rd_data_d  = (rd_verdict == ACC_PASS) ? flash_rdata_i : '0;
    vio_d      = (rd_verdict == ACC_BLOCK) || (wr_verdict == ACC_BLOCK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      vio_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      vio_q      <= vio_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_data_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign violation_o = vio_q;

endmodule

// File: rtl/pfm_access_guard.sv
module pfm_access_guard
  import pfm_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BOOT_BYTES = 2048,
  parameter int unsigned BLK_BYTES  = 4096,
  parameter int unsigned NUM_BLK    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   tptr_i,
  input  logic                rd_req_i,
  input  logic                wr_req_i,
  input  logic [DATA_W-1:0]   flash_rdata_i,
  output logic                flash_we_o,
  output logic                rd_valid_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                violation_o,
  input  logic                cfg_wr_i,
  input  logic [NUM_BLK:0]    cfg_wp_i,
  input  logic [NUM_BLK:0]    cfg_rp_i,
  input  logic                chip_erase_i,
  input  logic                blk_erase_i,
  input  logic [2:0]          blk_erase_sel_i,
  output logic [NUM_BLK:0]    wp_o,
  output logic [NUM_BLK:0]    rp_o
);

  localparam int unsigned NUM_REG = NUM_BLK + 1;
  localparam int unsigned IDX_W   = $clog2(NUM_REG + 1);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [IDX_W-1:0]   pc_idx, tgt_idx, sel_idx;
  logic [NUM_REG-1:0] wp_q, rp_q;

  assign sel_idx = IDX_W'(blk_erase_sel_i);

  pfm_region_decode #(
    .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
    .NUM_BLK(NUM_BLK), .IDX_W(IDX_W)
  ) u_pc_dec (
    .addr_i(pc_i),
    .idx_o (pc_idx)
  );

  pfm_region_decode #(
    .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
    .NUM_BLK(NUM_BLK), .IDX_W(IDX_W)
  ) u_tgt_dec (
    .addr_i(tptr_i),
    .idx_o (tgt_idx)
  );

  pfm_prot_store #(
    .NUM_REG(NUM_REG), .IDX_W(IDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wp_i    (cfg_wp_i),
    .cfg_rp_i    (cfg_rp_i),
    .chip_erase_i(chip_erase_i),
    .blk_erase_i (blk_erase_i),
    .blk_sel_i   (sel_idx),
    .wp_q_o      (wp_q),
    .rp_q_o      (rp_q)
  );

  pfm_access_gate #(
    .NUM_REG(NUM_REG), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .pc_idx_i     (pc_idx),
    .tgt_idx_i    (tgt_idx),
    .wp_i         (wp_q),
    .rp_i         (rp_q),
    .rd_req_i     (rd_req_i),
    .wr_req_i     (wr_req_i),
    .flash_rdata_i(flash_rdata_i),
    .flash_we_o   (flash_we_o),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .violation_o  (violation_o)
  );

  assign wp_o = wp_q;
  assign rp_o = rp_q;

endmodule

// File: rtl/pfm_access_guard_chk.sv
module pfm_access_guard_chk #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BOOT_BYTES = 2048,
  parameter int unsigned BLK_BYTES  = 4096,
  parameter int unsigned NUM_BLK    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] tptr_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic              flash_we_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              violation_o,
  input logic              chip_erase_i,
  input logic              blk_erase_i,
  input logic [NUM_BLK:0]  wp_o,
  input logic [NUM_BLK:0]  rp_o
);

  localparam logic [ADDR_W-1:0] B1_LO = ADDR_W'(BOOT_BYTES);
  localparam logic [ADDR_W-1:0] B1_HI = ADDR_W'(BLK_BYTES);
  localparam logic [ADDR_W-1:0] TOP   = ADDR_W'(NUM_BLK * BLK_BYTES);

  logic tgt_in_b1, pc_in_b1;
  assign tgt_in_b1 = (tptr_i >= B1_LO) && (tptr_i < B1_HI);
  assign pc_in_b1  = (pc_i   >= B1_LO) && (pc_i   < B1_HI);

  // R3
  wr_lock_b1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !wp_o[1] && tgt_in_b1) |-> !flash_we_o);

  // R5
  foreign_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !rp_o[1] && tgt_in_b1 && !pc_in_b1)
      |=> (rd_valid_o && (rd_data_o == '0) && violation_o));

  // R6
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && (tptr_i >= TOP)) |=> (rd_data_o == '0));

  // R7
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);

  // R8
  vio_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |-> $past(rd_req_i || wr_req_i));

  // R9
  bits_rise_by_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((wp_o & ~$past(wp_o)) != '0) || ((rp_o & ~$past(rp_o)) != '0))
      |-> $past(chip_erase_i || blk_erase_i));

  // R10
  chip_erase_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_i |=> ((&wp_o) && (&rp_o)));

endmodule

bind pfm_access_guard pfm_access_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_BYTES(BOOT_BYTES),
  .BLK_BYTES(BLK_BYTES), .NUM_BLK(NUM_BLK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_i        (pc_i),
  .tptr_i      (tptr_i),
  .rd_req_i    (rd_req_i),
  .wr_req_i    (wr_req_i),
  .flash_we_o  (flash_we_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .violation_o (violation_o),
  .chip_erase_i(chip_erase_i),
  .blk_erase_i (blk_erase_i),
  .wp_o        (wp_o),
  .rp_o        (rp_o)
);

// File: tb/pfm_access_guard_tb.sv
module pfm_access_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] pc, tptr;
  logic        rd_req, wr_req;
  logic [7:0]  flash_rdata, wdata;
  logic        flash_we_o, rd_valid_o, violation_o;
  logic [7:0]  rd_data_o;
  logic        cfg_wr, chip_erase, blk_erase;
  logic [4:0]  cfg_wp, cfg_rp, wp_o, rp_o;
  logic [2:0]  blk_sel;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  pfm_access_guard u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .tptr_i(tptr),
    .rd_req_i(rd_req), .wr_req_i(wr_req), .flash_rdata_i(flash_rdata),
    .flash_we_o(flash_we_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .violation_o(violation_o), .cfg_wr_i(cfg_wr), .cfg_wp_i(cfg_wp),
    .cfg_rp_i(cfg_rp), .chip_erase_i(chip_erase), .blk_erase_i(blk_erase),
    .blk_erase_sel_i(blk_sel), .wp_o(wp_o), .rp_o(rp_o)
  );

  // Flash array, driven only by the DUT's write strobe.
  logic [7:0] fmem [0:16383];
  assign flash_rdata = (tptr < 22'h4000) ? fmem[tptr[13:0]] : 8'hA5;
  always @(posedge clk) if (flash_we_o && tptr < 22'h4000) fmem[tptr[13:0]] <= wdata;

  // Reference model state.
  bit [4:0] m_wp, m_rp;
  bit [7:0] rmem [0:16383];

  function automatic int region_of(logic [21:0] a);
    if (a < 22'h0800) return 0;
    if (a < 22'h1000) return 1;
    if (a < 22'h2000) return 2;
    if (a < 22'h3000) return 3;
    if (a < 22'h4000) return 4;
    return -1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    rd_req = 0; wr_req = 0; cfg_wr = 0; chip_erase = 0; blk_erase = 0;
    blk_sel = 0; cfg_wp = '1; cfg_rp = '1; wdata = 0;
  endtask

  // One clock: inputs already driven after a falling edge.
  task automatic step();
    int t, p;
    bit rd_ok, wr_ok, den;
    bit [7:0] dat;
    #1;
    t = region_of(tptr);
    p = region_of(pc);
    wr_ok = (t >= 0) && m_wp[t];
    rd_ok = (t >= 0) && (m_rp[t] || p == t);
    chk("R3", "flash_we_o", flash_we_o, wr_req && wr_ok);
    dat = (rd_ok && t >= 0) ? rmem[tptr[13:0]] : 8'h00;
    den = (rd_req && !rd_ok) || (wr_req && !wr_ok);
    if (wr_req && wr_ok) rmem[tptr[13:0]] = wdata;
    if (chip_erase) begin
      m_wp = '1; m_rp = '1;
    end else if (blk_erase) begin
      if (blk_sel < 5) begin
        m_wp[blk_sel] = 1'b1; m_rp[blk_sel] = 1'b1;
      end
    end else if (cfg_wr) begin
      m_wp &= cfg_wp; m_rp &= cfg_rp;
    end
    @(negedge clk);
    chk("R7", "rd_valid_o", rd_valid_o, rd_req);
    if (rd_req) chk(rd_ok ? "R4" : "R5", "rd_data_o", rd_data_o, dat);
    chk("R8", "violation_o", violation_o, den);
    chk("R9", "wp_o", wp_o, m_wp);
    chk("R9", "rp_o", rp_o, m_rp);
  endtask

  task automatic rd(logic [21:0] p, logic [21:0] a);
    idle(); pc = p; tptr = a; rd_req = 1; step(); idle();
  endtask

  task automatic wr(logic [21:0] p, logic [21:0] a, logic [7:0] d);
    idle(); pc = p; tptr = a; wr_req = 1; wdata = d; step(); idle();
  endtask

  task automatic cfg(logic [4:0] w, logic [4:0] r);
    idle(); cfg_wr = 1; cfg_wp = w; cfg_rp = r; step(); idle();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16384; i++) begin
      fmem[i] = 8'(i ^ (i >> 8) ^ 8'h5A);
      rmem[i] = 8'(i ^ (i >> 8) ^ 8'h5A);
    end
    m_wp = '1; m_rp = '1;
    idle(); pc = 0; tptr = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "wp_o", wp_o, 5'h1F);
    chk("R1", "rp_o", rp_o, 5'h1F);
    chk("R1", "rd_valid_o", rd_valid_o, 0);
    chk("R1", "violation_o", violation_o, 0);

    // R2 R4: boundaries of every region, all bits open
    wr(22'h0100, 22'h07FF, 8'h11); wr(22'h0100, 22'h0800, 8'h22);
    wr(22'h0100, 22'h0FFF, 8'h33); wr(22'h0100, 22'h1000, 8'h44);
    wr(22'h0100, 22'h2FFF, 8'h55); wr(22'h0100, 22'h3000, 8'h66);
    wr(22'h0100, 22'h3FFF, 8'h77);
    rd(22'h3000, 22'h07FF); rd(22'h3000, 22'h0800); rd(22'h0000, 22'h0FFF);
    rd(22'h0000, 22'h1000); rd(22'h0000, 22'h2FFF); rd(22'h0000, 22'h3000);
    rd(22'h0000, 22'h3FFF);

    // R3: clear write-enable of region 1, foreign write rejected
    cfg(5'b11101, 5'b11111);
    wr(22'h1FFE, 22'h08FF, 8'h3C);
    rd(22'h1FFE, 22'h08FF);
    wr(22'h0900, 22'h0A00, 8'h3D);   // same region still rejected
    wr(22'h1FFE, 22'h07FF, 8'h81);   // neighbours open
    wr(22'h1FFE, 22'h1000, 8'h82);
    // R9: writing 1 to a cleared bit keeps it 0
    cfg(5'b11111, 5'b11111);
    // R4 R5: foreign-read lock on region 1
    cfg(5'b11111, 5'b11101);
    rd(22'h1FFE, 22'h0900);
    rd(22'h0A00, 22'h0900);
    rd(22'h07FF, 22'h0800);
    rd(22'h0800, 22'h0FFF);
    rd(22'h0900, 22'h1000);
    // R6: unmapped target
    rd(22'h0100, 22'h4000);
    wr(22'h0100, 22'h4000, 8'h99);
    rd(22'h5000, 22'h1000);
    rd(22'h5000, 22'h0900);
    // R11 R12: region erase beats a same-cycle configuration write
    idle(); blk_erase = 1; blk_sel = 3'd1; cfg_wr = 1; cfg_wp = 5'b11110; cfg_rp = 5'b11110;
    step(); idle();
    cfg(5'b00000, 5'b00000);
    idle(); blk_erase = 1; blk_sel = 3'd3; step(); idle();
    idle(); blk_erase = 1; blk_sel = 3'd6; cfg_wr = 1; cfg_wp = 5'b11111; step(); idle();
    wr(22'h0100, 22'h2000, 8'hC3);
    wr(22'h0100, 22'h1000, 8'hC4);
    rd(22'h0100, 22'h2000);
    rd(22'h0200, 22'h0100);
    rd(22'h0100, 22'h3800);
    // R10 R12: chip erase beats region erase and configuration write
    idle(); chip_erase = 1; blk_erase = 1; blk_sel = 3'd0; cfg_wr = 1; cfg_wp = 0; cfg_rp = 0;
    step(); idle();

    // Mixed traffic
    for (int n = 0; n < 600; n++) begin
      int k;
      idle();
      k = int'($urandom_range(0, 19));
      pc     = 22'($urandom_range(0, 22'h47FF));
      tptr   = 22'($urandom_range(0, 22'h47FF));
      rd_req = $urandom_range(0, 1) == 1;
      wr_req = $urandom_range(0, 2) == 0;
      wdata  = 8'($urandom);
      if (k == 0) begin cfg_wr = 1; cfg_wp = 5'($urandom); cfg_rp = 5'($urandom); end
      if (k == 1) begin blk_erase = 1; blk_sel = 3'($urandom); end
      if (k == 2) chip_erase = 1;
      if (k == 3) begin cfg_wr = 1; cfg_wp = 5'($urandom); blk_erase = 1; blk_sel = 3'($urandom); end
      step();
    end
    idle(); step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule